// File: doc/BRIEF.md
# Processor Status Word Register Unit

This block holds the status word of a simple processor control path. The word is 128 bits wide. The upper 64 bits carry the interrupt mask bits, a 4-bit protection key and the machine-check, wait and problem-state bits. They also carry the address-space control, the condition code, the program mask and the two addressing-mode bits. The lower 64 bits carry the instruction address. Bits are numbered from the left: bit 0 is the most significant bit of the upper word, and bit 64 is the most significant bit of the instruction address.

Privileged code replaces the whole word through one of two load paths. A 128-bit long-format load is stored as given. A 64-bit short-format load is expanded into the same internal long form before it is stored. Each load is checked against the format, reserved-bit and addressing-mode rules. A failing load leaves the register untouched and produces a one-cycle exception pulse. Unprivileged paths can write the condition code (from arithmetic results) and the program mask. A combinational evaluator tests the stored condition code against a 4-bit branch mask. The upper word is always visible on an extract port.

Top module: `status_word_unit`

## Requirements
- R1: After reset, status_hi and instr_addr are all zeros, and spec_exception and priv_exception are low.
- R2: status_hi is bit 0..63 of the word with bit 0 at status_hi[63]. The positions are: bit 1 event mask, bit 5 translation, bit 6 I/O mask, bit 7 external mask, bits 8..11 key, bit 12 format, bit 13 machine-check mask, bit 14 wait, bit 15 problem state, bits 16..17 address space (00 primary, 01 access-register, 10 secondary, 11 home), bits 18..19 condition code, bits 20..23 program mask, bit 31 extended addressing, bit 32 basic addressing. instr_addr is bits 64..127.
- R3: A long-format load (128-bit word, bits 0..127 at lng_ld_word[127:0], MSB first) is accepted only with bit 12 = 0. When accepted, its upper half becomes status_hi and its lower half becomes instr_addr.
- R4: A short-format load (64-bit word) is accepted only with bit 12 = 1. When accepted, it is stored with bit 12 cleared and bits 33..63 of status_hi zero. Its bits 33..63 become instr_addr, zero-extended.
- R5: A load is rejected if any of the following bits is set: bit 0, bits 2..4 or bits 24..30 (either format), or bits 33..63 of a long-format load.
- R6: The pair (bit 31, bit 32) selects the addressing mode: 00 gives 24-bit, 01 gives 31-bit, 10 gives 64-bit, and 11 is rejected. A load is also rejected when its instruction address does not fit the selected mode's width.
- R7: A rejected load leaves status_hi and instr_addr unchanged. spec_exception is high for exactly the one cycle after the request.
- R8: While bit 15 (problem state) is set, every load is rejected. priv_exception pulses instead of spec_exception, and the register is unchanged.
- R9: cc_wr_val writes bits 18..19 and pm_wr_val writes bits 20..23, in any state. pm_wr_val[3] is bit 20 (fixed-point overflow), then decimal overflow, exponent underflow and significance.
- R10: br_taken is high when the mask bit for the stored condition code is set. Mask value 8 (br_mask[3]) selects code 0, 4 selects code 1, 2 selects code 2 and 1 selects code 3.
- R11: If both loads are requested in the same cycle, the long-format load is the one evaluated. In any cycle with a load request, accepted or not, the condition-code and program-mask writes are dropped.
- R12: An accepted load that carries the wait bit (bit 14) as 0 clears a wait bit that was set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lng_ld_valid | input | 1 | Long-format load request |
| lng_ld_word | input | 128 | Long-format image, bit 0 at [127] |
| sht_ld_valid | input | 1 | Short-format load request |
| sht_ld_word | input | 64 | Short-format image, bit 0 at [63] |
| cc_wr_valid | input | 1 | Condition-code write strobe |
| cc_wr_val | input | 2 | New condition code |
| pm_wr_valid | input | 1 | Program-mask write strobe |
| pm_wr_val | input | 4 | New program mask |
| br_mask | input | 4 | Branch mask to test |
| br_taken | output | 1 | Branch condition met |
| status_hi | output | 64 | Extract port: upper word |
| instr_addr | output | 64 | Stored instruction address |
| spec_exception | output | 1 | One-cycle pulse: load rejected on format |
| priv_exception | output | 1 | One-cycle pulse: load rejected on privilege |

## Verification
The bench builds the unit with its default parameters: a 64-bit word, the short-load path enabled and long-over-short precedence. With these settings every validation rule of both formats can be reached, and so can the precedence between a simultaneous long and short request. The disabled short path and the short-first precedence variant are not instantiated, so their generate branches remain unexercised.

// File: rtl/stw_pkg.sv
package stw_pkg;

   localparam int unsigned HW     = 64;
   localparam int unsigned CC_W   = 2;
   localparam int unsigned PM_W   = 4;
   localparam int unsigned KEY_W  = 4;
   localparam int unsigned ADDR24 = 24;
   localparam int unsigned ADDR31 = 31;

   // left-numbered bit positions inside the upper word
   localparam int unsigned B_EVT  = 1;
   localparam int unsigned B_XLT  = 5;
   localparam int unsigned B_IOM  = 6;
   localparam int unsigned B_EXM  = 7;
   localparam int unsigned B_KEY  = 8;
   localparam int unsigned B_FMT  = 12;
   localparam int unsigned B_MCK  = 13;
   localparam int unsigned B_WAIT = 14;
   localparam int unsigned B_PROB = 15;
   localparam int unsigned B_ASC  = 16;
   localparam int unsigned B_CC   = 18;
   localparam int unsigned B_PM   = 20;
   localparam int unsigned B_EXTA = 31;
   localparam int unsigned B_BASA = 32;
   localparam int unsigned B_SIA  = 33;

   typedef enum logic [1:0] {
      AM_24  = 2'b00,
      AM_31  = 2'b01,
      AM_64  = 2'b10,
      AM_BAD = 2'b11
   } amode_e;

   // left-numbered bit to vector index
   function automatic int unsigned pos(input int unsigned b);
      return HW - 1 - b;
   endfunction

   // bits that must be clear in a loaded upper word
   function automatic logic [HW-1:0] rsv_mask(input logic long_fmt);
      logic [HW-1:0] m;
      m = '0;
      for (int b = 0; b < HW; b++) begin
         if (b == 0 || (b >= 2 && b <= 4) || (b >= 24 && b <= 30) ||
             (long_fmt && b >= int'(B_SIA)))
            m[HW-1-b] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/stw_load_check.sv
module stw_load_check
   import stw_pkg::*;
#(
   parameter int unsigned WORD_W   = 64,
   parameter bit          LONG_FMT = 1'b1,
   parameter bit          ENABLE   = 1'b1
) (
   input  logic [(LONG_FMT ? 2*WORD_W : WORD_W)-1:0] word_in,
   output logic                                      ok,
   output logic [WORD_W-1:0]                         img_hi,
   output logic [WORD_W-1:0]                         img_ia
);

   localparam int unsigned SIA_W = WORD_W - B_SIA;

   logic [WORD_W-1:0] hi_raw;
   logic              fmt_ok;
   logic              rsv_ok;
   logic              fit_ok;
   amode_e            am;

   if (LONG_FMT) begin : g_long
      assign hi_raw = word_in[2*WORD_W-1 -: WORD_W];
      assign img_ia = word_in[WORD_W-1:0];
      assign img_hi = hi_raw;
      assign fmt_ok = ~hi_raw[pos(B_FMT)];
   end else begin : g_short
      assign hi_raw = word_in;
      assign img_ia = {{(WORD_W-SIA_W){1'b0}}, word_in[SIA_W-1:0]};
      assign fmt_ok = hi_raw[pos(B_FMT)];
      always_comb begin
         img_hi               = hi_raw;
         img_hi[pos(B_FMT)]   = 1'b0;
         img_hi[SIA_W-1:0]    = '0;
      end
   end

   assign am     = amode_e'({hi_raw[pos(B_EXTA)], hi_raw[pos(B_BASA)]});
   assign rsv_ok = ((hi_raw & rsv_mask(LONG_FMT)) == '0);

   always_comb begin
      unique case (am)
         AM_24:   fit_ok = (img_ia[WORD_W-1:ADDR24] == '0);
         AM_31:   fit_ok = (img_ia[WORD_W-1:ADDR31] == '0);
         AM_64:   fit_ok = 1'b1;
         default: fit_ok = 1'b0;
      endcase
   end

   assign ok = ENABLE ? (fmt_ok & rsv_ok & fit_ok) : 1'b0;

endmodule

// File: rtl/stw_user_fields.sv
module stw_user_fields
   import stw_pkg::*;
#(
   parameter int unsigned WORD_W = 64
) (
   input  logic [WORD_W-1:0] cur_hi,
   input  logic              cc_v,
   input  logic [CC_W-1:0]   cc_val,
   input  logic              pm_v,
   input  logic [PM_W-1:0]   pm_val,
   output logic [WORD_W-1:0] nxt_hi
);

   always_comb begin
      nxt_hi = cur_hi;
      if (cc_v) nxt_hi[pos(B_CC) -: CC_W] = cc_val;
      if (pm_v) nxt_hi[pos(B_PM) -: PM_W] = pm_val;
   end

endmodule

// File: rtl/stw_branch_eval.sv
module stw_branch_eval #(
   parameter int unsigned CC_BITS = 2
) (
   input  logic [CC_BITS-1:0]       cc,
   input  logic [(1<<CC_BITS)-1:0]  mask,
   output logic                     taken
);

   localparam int unsigned NSEL = 1 << CC_BITS;

   logic [NSEL-1:0] hit;

   // leftmost mask bit tests code zero
   for (genvar g = 0; g < NSEL; g++) begin : g_sel
      assign hit[g] = mask[NSEL-1-g] & (cc == CC_BITS'(g));
   end

   assign taken = |hit;

endmodule

// File: rtl/status_word_unit.sv
module status_word_unit
   import stw_pkg::*;
#(
   parameter int unsigned WORD_W        = 64,
   parameter bit          SHORT_LOAD_EN = 1'b1,
   parameter bit          LONG_WINS     = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lng_ld_valid,
   input  logic [2*WORD_W-1:0] lng_ld_word,
   input  logic                sht_ld_valid,
   input  logic [WORD_W-1:0]   sht_ld_word,
   input  logic                cc_wr_valid,
   input  logic [1:0]          cc_wr_val,
   input  logic                pm_wr_valid,
   input  logic [3:0]          pm_wr_val,
   input  logic [3:0]          br_mask,
   output logic                br_taken,
   output logic [WORD_W-1:0]   status_hi,
   output logic [WORD_W-1:0]   instr_addr,
   output logic                spec_exception,
   output logic                priv_exception
);

   localparam int unsigned NMASK = 1 << CC_W;

   if (WORD_W != HW) begin : g_bad_width
      $error("status_word_unit: WORD_W must equal the fixed field layout width");
   end
   if (NMASK != 4 || PM_W != 4 || KEY_W != 4) begin : g_bad_fields
      $error("status_word_unit: field widths do not match the layout");
   end

   logic [WORD_W-1:0] stat_hi, stat_ia;
   logic              spec_q, priv_q;

   logic              l_ok, s_ok;
   logic [WORD_W-1:0] l_hi, l_ia, s_hi, s_ia;
   logic              take_long, load_req, in_problem, sel_ok;
   logic [WORD_W-1:0] sel_hi, sel_ia, user_hi;

   stw_load_check #(.WORD_W(WORD_W), .LONG_FMT(1'b1), .ENABLE(1'b1)) u_chk_long (
      .word_in (lng_ld_word),
      .ok      (l_ok),
      .img_hi  (l_hi),
      .img_ia  (l_ia)
   );

   stw_load_check #(.WORD_W(WORD_W), .LONG_FMT(1'b0), .ENABLE(SHORT_LOAD_EN)) u_chk_short (
      .word_in (sht_ld_word),
      .ok      (s_ok),
      .img_hi  (s_hi),
      .img_ia  (s_ia)
   );

   stw_user_fields #(.WORD_W(WORD_W)) u_user (
      .cur_hi (stat_hi),
      .cc_v   (cc_wr_valid),
      .cc_val (cc_wr_val),
      .pm_v   (pm_wr_valid),
      .pm_val (pm_wr_val),
      .nxt_hi (user_hi)
   );

   stw_branch_eval #(.CC_BITS(CC_W)) u_branch (
      .cc    (stat_hi[pos(B_CC) -: CC_W]),
      .mask  (br_mask),
      .taken (br_taken)
   );

   if (LONG_WINS) begin : g_long_first
      assign take_long = lng_ld_valid;
   end else begin : g_short_first
      assign take_long = lng_ld_valid & ~sht_ld_valid;
   end

   assign load_req   = lng_ld_valid | sht_ld_valid;
   assign in_problem = stat_hi[pos(B_PROB)];
   assign sel_ok     = take_long ? l_ok : s_ok;
   assign sel_hi     = take_long ? l_hi : s_hi;
   assign sel_ia     = take_long ? l_ia : s_ia;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_hi <= '0;
         stat_ia <= '0;
         spec_q  <= 1'b0;
         priv_q  <= 1'b0;
      end else begin
         spec_q <= load_req & ~in_problem & ~sel_ok;
         priv_q <= load_req & in_problem;
         if (load_req) begin
            if (!in_problem && sel_ok) begin
               stat_hi <= sel_hi;
               stat_ia <= sel_ia;
            end
         end else begin
            stat_hi <= user_hi;
         end
      end
   end

   assign status_hi      = stat_hi;
   assign instr_addr     = stat_ia;
   assign spec_exception = spec_q;
   assign priv_exception = priv_q;

   // R7: a rejected load leaves the word as it was
   p_reject_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      spec_q |-> (stat_hi == $past(stat_hi) && stat_ia == $past(stat_ia)));

   // R8: no write while in problem state
   p_priv_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      priv_q |-> (stat_hi == $past(stat_hi) && stat_ia == $past(stat_ia)));

   p_one_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(spec_q && priv_q));

   // R6: the invalid mode pair is never stored
   p_no_bad_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(stat_hi[pos(B_EXTA)] && stat_hi[pos(B_BASA)]));

   p_ia24_fit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_hi[pos(B_EXTA)] && !stat_hi[pos(B_BASA)]) |-> (stat_ia[WORD_W-1:ADDR24] == '0));

   p_ia31_fit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_hi[pos(B_EXTA)] && stat_hi[pos(B_BASA)]) |-> (stat_ia[WORD_W-1:ADDR31] == '0));

   // R4: internal form always carries the long-format marker
   p_internal_form_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_hi[pos(B_FMT)]);

   // R9: an unblocked condition-code write lands one cycle later
   p_cc_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cc_wr_valid && !load_req) |=> (stat_hi[pos(B_CC) -: CC_W] == $past(cc_wr_val)));

   // R11: a load request blocks the condition-code write
   p_cc_blocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (load_req && (in_problem || !sel_ok)) |=> $stable(stat_hi));

   // R10: an empty mask never branches
   p_empty_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (br_mask == '0) |-> !br_taken);

endmodule

// File: tb/tb_status_word_unit.sv
`timescale 1ns/1ps
module tb_status_word_unit;

   localparam logic [1:0] OP_L = 2'd0, OP_S = 2'd1, OP_C = 2'd2, OP_P = 2'd3;

   // flag byte order: {evt, xlt, iom, exm, fmt, mck, wait, prob}
   function automatic logic [63:0] hw(input logic [7:0] fl, input logic [3:0] key,
                                      input logic [1:0] asc, input logic [1:0] cc,
                                      input logic [3:0] pm, input logic [1:0] am);
      logic [63:0] w;
      w = '0;
      w[62] = fl[7]; w[58] = fl[6]; w[57] = fl[5]; w[56] = fl[4];
      w[55:52] = key;
      w[51] = fl[3]; w[50] = fl[2]; w[49] = fl[1]; w[48] = fl[0];
      w[47:46] = asc; w[45:44] = cc; w[43:40] = pm;
      w[32] = am[1]; w[31] = am[0];
      return w;
   endfunction

   typedef struct packed {
      logic [1:0]   op;
      logic [127:0] data;
      logic         spec;
      logic         priv;
      logic [63:0]  hi;
      logic [63:0]  ia;
      logic [3:0]   req;
   } vec_t;

   localparam logic [63:0] H1  = hw(8'b0011_0100, 4'd5, 2'd2, 2'd1, 4'b1010, 2'b01);
   localparam logic [63:0] IA1 = 64'h0000_0000_1234_5678;
   localparam logic [63:0] H5  = hw(8'b0, 4'd3, 2'd0, 2'd0, 4'b0, 2'b00);
   localparam logic [63:0] H7  = hw(8'b1100_0000, 4'hF, 2'd3, 2'd3, 4'hF, 2'b10);
   localparam logic [63:0] IA7 = 64'hFFFF_0000_0000_0010;
   localparam logic [63:0] H9  = hw(8'b0, 4'd9, 2'd1, 2'd3, 4'b0001, 2'b01);
   localparam logic [63:0] S9  = hw(8'b0000_1000, 4'd9, 2'd1, 2'd3, 4'b0001, 2'b01) | 64'h7ABC_DEF0;
   localparam logic [63:0] H14 = hw(8'b0, 4'd2, 2'd0, 2'd0, 4'b0, 2'b10);
   localparam logic [63:0] H17 = hw(8'b0000_0011, 4'd6, 2'd0, 2'd1, 4'b0, 2'b01);

   localparam int NV = 21;
   localparam vec_t VT [NV] = '{
      // R3 accepted long load
      '{OP_L, {H1, IA1}, 1'b0, 1'b0, H1, IA1, 4'd3},
      // R3 long with format bit set
      '{OP_L, {hw(8'b0011_1100, 4'd5, 2'd2, 2'd1, 4'b1010, 2'b01), IA1}, 1'b1, 1'b0, H1, IA1, 4'd3},
      // R6 mode pair 11
      '{OP_L, {hw(8'b0, 4'd1, 2'd0, 2'd0, 4'b0, 2'b11), 64'h10}, 1'b1, 1'b0, H1, IA1, 4'd6},
      // R5 reserved bit 26
      '{OP_L, {H1 | (64'd1 << 37), IA1}, 1'b1, 1'b0, H1, IA1, 4'd5},
      // R6 24-bit mode, address too wide
      '{OP_L, {H5, 64'h0100_0000}, 1'b1, 1'b0, H1, IA1, 4'd6},
      // R6 24-bit mode, top address fits
      '{OP_L, {H5, 64'h00FF_FFFE}, 1'b0, 1'b0, H5, 64'h00FF_FFFE, 4'd6},
      // R6 64-bit mode with full address
      '{OP_L, {H7, IA7}, 1'b0, 1'b0, H7, IA7, 4'd6},
      // R5 long with bit 40 set
      '{OP_L, {H7 | (64'd1 << 23), IA7}, 1'b1, 1'b0, H7, IA7, 4'd5},
      // R4 accepted short load
      '{OP_S, {64'd0, S9}, 1'b0, 1'b0, H9, 64'h7ABC_DEF0, 4'd4},
      // R4 short without format bit
      '{OP_S, {64'd0, H9 | 64'h10}, 1'b1, 1'b0, H9, 64'h7ABC_DEF0, 4'd4},
      // R6 short 24-bit with wide address
      '{OP_S, {64'd0, hw(8'b0000_1000, 4'd0, 2'd0, 2'd0, 4'b0, 2'b00) | 64'h0100_0000}, 1'b1, 1'b0, H9, 64'h7ABC_DEF0, 4'd6},
      // R6 short mode pair 11
      '{OP_S, {64'd0, hw(8'b0000_1000, 4'd0, 2'd0, 2'd0, 4'b0, 2'b11)}, 1'b1, 1'b0, H9, 64'h7ABC_DEF0, 4'd6},
      // R5 short reserved bit 3
      '{OP_S, {64'd0, S9 | (64'd1 << 60)}, 1'b1, 1'b0, H9, 64'h7ABC_DEF0, 4'd5},
      // R4 short in 64-bit mode
      '{OP_S, {64'd0, hw(8'b0000_1000, 4'd2, 2'd0, 2'd0, 4'b0, 2'b10) | 64'h7FFF_FFFF}, 1'b0, 1'b0, H14, 64'h7FFF_FFFF, 4'd4},
      // R9 condition code write
      '{OP_C, 128'd2, 1'b0, 1'b0, hw(8'b0, 4'd2, 2'd0, 2'd2, 4'b0, 2'b10), 64'h7FFF_FFFF, 4'd9},
      // R9 program mask write
      '{OP_P, 128'h5, 1'b0, 1'b0, hw(8'b0, 4'd2, 2'd0, 2'd2, 4'b0101, 2'b10), 64'h7FFF_FFFF, 4'd9},
      // R2 enter problem state with wait set
      '{OP_L, {H17, 64'h100}, 1'b0, 1'b0, H17, 64'h100, 4'd2},
      // R8 valid long load in problem state
      '{OP_L, {H1, IA1}, 1'b0, 1'b1, H17, 64'h100, 4'd8},
      // R8 bad short load in problem state
      '{OP_S, {64'd0, H9}, 1'b0, 1'b1, H17, 64'h100, 4'd8},
      // R9 condition code write in problem state
      '{OP_C, 128'd3, 1'b0, 1'b0, hw(8'b0000_0011, 4'd6, 2'd0, 2'd3, 4'b0, 2'b01), 64'h100, 4'd9},
      // R9 program mask write in problem state
      '{OP_P, 128'hF, 1'b0, 1'b0, hw(8'b0000_0011, 4'd6, 2'd0, 2'd3, 4'hF, 2'b01), 64'h100, 4'd9}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         lng_ld_valid = 1'b0;
   logic [127:0] lng_ld_word = '0;
   logic         sht_ld_valid = 1'b0;
   logic [63:0]  sht_ld_word = '0;
   logic         cc_wr_valid = 1'b0;
   logic [1:0]   cc_wr_val = '0;
   logic         pm_wr_valid = 1'b0;
   logic [3:0]   pm_wr_val = '0;
   logic [3:0]   br_mask = '0;
   logic         br_taken;
   logic [63:0]  status_hi, instr_addr;
   logic         spec_exception, priv_exception;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   status_word_unit dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .lng_ld_valid   (lng_ld_valid),
      .lng_ld_word    (lng_ld_word),
      .sht_ld_valid   (sht_ld_valid),
      .sht_ld_word    (sht_ld_word),
      .cc_wr_valid    (cc_wr_valid),
      .cc_wr_val      (cc_wr_val),
      .pm_wr_valid    (pm_wr_valid),
      .pm_wr_val      (pm_wr_val),
      .br_mask        (br_mask),
      .br_taken       (br_taken),
      .status_hi      (status_hi),
      .instr_addr     (instr_addr),
      .spec_exception (spec_exception),
      .priv_exception (priv_exception)
   );

   task automatic idle_inputs();
      lng_ld_valid = 1'b0; sht_ld_valid = 1'b0;
      cc_wr_valid  = 1'b0; pm_wr_valid  = 1'b0;
   endtask

   task automatic drive(input logic [1:0] op, input logic [127:0] d);
      @(negedge clk);
      idle_inputs();
      case (op)
         OP_L: begin lng_ld_valid = 1'b1; lng_ld_word = d; end
         OP_S: begin sht_ld_valid = 1'b1; sht_ld_word = d[63:0]; end
         OP_C: begin cc_wr_valid = 1'b1; cc_wr_val = d[1:0]; end
         default: begin pm_wr_valid = 1'b1; pm_wr_val = d[3:0]; end
      endcase
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic check_state(input string tag, input logic [63:0] e_hi, input logic [63:0] e_ia,
                              input logic e_spec, input logic e_priv);
      checks++;
      if (status_hi !== e_hi || instr_addr !== e_ia ||
          spec_exception !== e_spec || priv_exception !== e_priv) begin
         fails++;
         $display("FAIL %s: got hi=%h ia=%h spec=%b priv=%b, expected hi=%h ia=%h spec=%b priv=%b",
                  tag, status_hi, instr_addr, spec_exception, priv_exception,
                  e_hi, e_ia, e_spec, e_priv);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_state("R1 reset state", 64'd0, 64'd0, 1'b0, 1'b0);

      for (int i = 0; i < NV; i++) begin
         drive(VT[i].op, VT[i].data);
         check_state($sformatf("R%0d vector %0d", VT[i].req, i),
                     VT[i].hi, VT[i].ia, VT[i].spec, VT[i].priv);
      end

      // R10 branch mask sweep over every code
      for (int cc = 0; cc < 4; cc++) begin
         drive(OP_C, 128'(cc));
         for (int m = 0; m < 16; m++) begin
            br_mask = 4'(m);
            #1;
            checks++;
            if (br_taken !== ((4'(m) & (4'd8 >> cc)) != 4'd0)) begin
               fails++;
               $display("FAIL R10 cc=%0d mask=%h: got %b, expected %b", cc, m, br_taken,
                        ((4'(m) & (4'd8 >> cc)) != 4'd0));
            end
         end
      end
      br_mask = '0;

      // restart in supervisor state
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      // R11 simultaneous long and short load: long wins
      @(negedge clk);
      lng_ld_valid = 1'b1; lng_ld_word = {H1, IA1};
      sht_ld_valid = 1'b1; sht_ld_word = S9;
      @(negedge clk);
      idle_inputs();
      check_state("R11 long over short", H1, IA1, 1'b0, 1'b0);

      // R11 rejected load also drops a same-cycle cc write
      @(negedge clk);
      lng_ld_valid = 1'b1; lng_ld_word = {H1 | (64'd1 << 51), IA1};
      cc_wr_valid  = 1'b1; cc_wr_val = 2'd0;
      @(negedge clk);
      idle_inputs();
      check_state("R11 cc write dropped on load", H1, IA1, 1'b1, 1'b0);

      // R7 the exception lasts a single cycle
      @(negedge clk);
      check_state("R7 pulse ends", H1, IA1, 1'b0, 1'b0);

      // R12 wait bit set, then cleared by a later load
      drive(OP_L, {hw(8'b0000_0010, 4'd1, 2'd0, 2'd0, 4'b0, 2'b01), 64'h40});
      check_state("R12 wait set", hw(8'b0000_0010, 4'd1, 2'd0, 2'd0, 4'b0, 2'b01), 64'h40, 1'b0, 1'b0);
      drive(OP_L, {hw(8'b0, 4'd1, 2'd0, 2'd0, 4'b0, 2'b01), 64'h80});
      check_state("R12 wait cleared", hw(8'b0, 4'd1, 2'd0, 2'd0, 4'b0, 2'b01), 64'h80, 1'b0, 1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule